// File: doc/BRIEF.md
# Register-Triggered External SRAM Access Unit

This peripheral lets a processor reach a word-wide external SRAM-style memory one word at a time, using four bus-visible registers. Accesses are not started by a command register. Instead, they start as a side effect of ordinary register traffic. Storing a word into the write-data register launches an external write at the current offset. An external read is launched in one of two ways, selected by a configuration bit:

- **Offset-triggered mode:** storing a new offset launches the read.
- **Prefetch mode:** reading the data register hands back the word fetched earlier and launches a fetch at the current offset.

Every access holds the chip enable for a programmable number of wait cycles plus one cycle. Software learns that an access is over by polling a busy/done pair in the control word, or by taking an interrupt. An optional auto-increment advances the offset after each completed access, so a block of words can be streamed with one register operation per word.

Top module: `xmem_access_unit`

## Requirements
- R1: After reset, the following are all zero: the chip enable, the write enable, the interrupt, the control word (register index 0) and the offset (register index 1).
- R2: A bus write to register index 2 (WDATA) while idle starts an external write of that value at the current offset. The write enable stays high for the whole access, and the word lands at that address.
- R3: Every access keeps the chip enable high for exactly WAIT+1 cycles, where WAIT is control bits [2:0]. The address stays stable throughout, and the write enable never rises during a read.
- R4: When control bit 4 (PREF) is 0, a bus write to register index 1 (OFFSET) while idle stores the offset and starts an external read at the written address. After completion, register index 3 (RDATA) returns the fetched word.
- R5: When PREF is 1, a bus read of RDATA returns the previously fetched word and starts a fetch at the current offset. In this mode, an OFFSET write only stores the offset and starts no access.
- R6: When control bit 3 (INC) is 1, the offset increases by one after each completed access. When INC is 0, the offset is unchanged.
- R7: Control bit 8 (BUSY) reads 1 from the cycle after a launch until the access completes.
- R8: While busy, writes to OFFSET or WDATA, and in prefetch mode reads of RDATA, are ignored and set the sticky bit 10 (COLL). Writing 1 to bit 10 of the control word clears COLL.
- R9: Completion sets control bit 9 (DONE). The irq output equals DONE AND bit 5 (IRQ_EN). Writing 1 to bit 9 clears DONE, but a completion in the same cycle as that clear leaves DONE set.
- R10: When PREF is 0, a bus read of RDATA launches no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | One-cycle register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register index (0 control, 1 offset, 2 write data, 3 read data) |
| bus_wdata | input | DATA_W | Register write data |
| bus_rdata | output | DATA_W | Register read data (combinational) |
| mem_addr | output | ADDR_W | External memory address |
| mem_wdata | output | DATA_W | External memory write data |
| mem_rdata | input | DATA_W | External memory read data |
| mem_ce | output | 1 | External chip enable |
| mem_we | output | 1 | External write enable |
| irq | output | 1 | Completion interrupt |

## Verification
The bench also exercises the full sweep of wait counts, auto-increment settings and both read-trigger modes against a behavioural memory. The delicate overlap, however, is between the sequencer finishing an access and software clearing DONE through the control register on the same clock edge. The bench provokes this with a zero-wait write: the write to WDATA is followed, with no idle cycle, by a control write carrying the DONE clear. Because completion has priority, DONE and irq must both read back as 1 afterwards, and a later clear on its own must bring them to 0.

// File: rtl/xau_pkg.sv
package xau_pkg;
   localparam int WAIT_W    = 3;
   localparam int BIT_INC   = 3;
   localparam int BIT_PREF  = 4;
   localparam int BIT_IRQEN = 5;
   localparam int BIT_BUSY  = 8;
   localparam int BIT_DONE  = 9;
   localparam int BIT_COLL  = 10;
   localparam int CTRL_MSB  = BIT_COLL;

   typedef enum logic [1:0] {
      REG_CTRL = 2'd0,
      REG_OFFS = 2'd1,
      REG_WDAT = 2'd2,
      REG_RDAT = 2'd3
   } xau_reg_e;
endpackage

// File: rtl/xau_seq.sv
module xau_seq
   import xau_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              start_wr,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic [DATA_W-1:0] start_wdata,
   input  logic [WAIT_W-1:0] wait_cycles,
   output logic              busy,
   output logic              cmpl,
   output logic [DATA_W-1:0] rd_word,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              mem_ce,
   output logic              mem_we
);
   logic              busy_q, wr_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q, rd_q;
   logic [WAIT_W-1:0] cnt_q;

   assign cmpl      = busy_q && (cnt_q == '0);
   assign busy      = busy_q;
   assign rd_word   = rd_q;
   assign mem_addr  = addr_q;
   assign mem_wdata = wdata_q;
   assign mem_ce    = busy_q;
   assign mem_we    = busy_q && wr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         wr_q    <= 1'b0;
         addr_q  <= '0;
         wdata_q <= '0;
         rd_q    <= '0;
         cnt_q   <= '0;
      end else if (start && !busy_q) begin
         busy_q  <= 1'b1;
         wr_q    <= start_wr;
         addr_q  <= start_addr;
         wdata_q <= start_wdata;
         cnt_q   <= wait_cycles;
      end else if (busy_q) begin
         if (cnt_q == '0) begin
            busy_q <= 1'b0;
            if (!wr_q) rd_q <= mem_rdata;
         end else begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

   AST_WE_INSIDE_CE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> mem_ce); // R3
   AST_ACCESS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_ce && !cmpl) |=> (mem_ce && $stable(mem_addr) && $stable(mem_we))); // R3
   AST_RD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      (cmpl && !mem_we) |=> (rd_word == $past(mem_rdata))); // R4
endmodule

// File: rtl/xau_regs.sv
module xau_regs
   import xau_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [1:0]        bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              busy,
   input  logic              cmpl,
   input  logic [DATA_W-1:0] rd_word,
   output logic              start,
   output logic              start_wr,
   output logic [ADDR_W-1:0] start_addr,
   output logic [DATA_W-1:0] start_wdata,
   output logic [WAIT_W-1:0] wait_cycles,
   output logic              irq_raw
);
   logic [WAIT_W-1:0] wait_q;
   logic              inc_q, pref_q, irqen_q, done_q, coll_q;
   logic [ADDR_W-1:0] offs_q;
   logic [DATA_W-1:0] wdat_q;

   logic wr_acc, rd_acc, wr_ctrl, trig_offs, trig_wdat, trig_rd, any_trig;

   assign wr_acc    = bus_sel && bus_wr;
   assign rd_acc    = bus_sel && !bus_wr;
   assign wr_ctrl   = wr_acc && (bus_addr == REG_CTRL);
   assign trig_offs = wr_acc && (bus_addr == REG_OFFS);
   assign trig_wdat = wr_acc && (bus_addr == REG_WDAT);
   assign trig_rd   = rd_acc && (bus_addr == REG_RDAT) && pref_q;
   assign any_trig  = trig_offs || trig_wdat || trig_rd;

   assign start       = (trig_wdat || trig_rd || (trig_offs && !pref_q)) && !busy;
   assign start_wr    = trig_wdat;
   assign start_addr  = trig_offs ? bus_wdata[ADDR_W-1:0] : offs_q;
   assign start_wdata = bus_wdata;
   assign wait_cycles = wait_q;
   assign irq_raw     = done_q && irqen_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wait_q  <= '0;
         inc_q   <= 1'b0;
         pref_q  <= 1'b0;
         irqen_q <= 1'b0;
         done_q  <= 1'b0;
         coll_q  <= 1'b0;
         offs_q  <= '0;
         wdat_q  <= '0;
      end else begin
         if (wr_ctrl) begin
            wait_q  <= bus_wdata[WAIT_W-1:0];
            inc_q   <= bus_wdata[BIT_INC];
            pref_q  <= bus_wdata[BIT_PREF];
            irqen_q <= bus_wdata[BIT_IRQEN];
         end
         if (cmpl)                                done_q <= 1'b1;
         else if (wr_ctrl && bus_wdata[BIT_DONE]) done_q <= 1'b0;
         if (any_trig && busy)                    coll_q <= 1'b1;
         else if (wr_ctrl && bus_wdata[BIT_COLL]) coll_q <= 1'b0;
         if (trig_offs && !busy)                  offs_q <= bus_wdata[ADDR_W-1:0];
         else if (cmpl && inc_q)                  offs_q <= offs_q + 1'b1;
         if (trig_wdat && !busy)                  wdat_q <= bus_wdata;
      end
   end

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         REG_CTRL: begin
            bus_rdata[WAIT_W-1:0] = wait_q;
            bus_rdata[BIT_INC]    = inc_q;
            bus_rdata[BIT_PREF]   = pref_q;
            bus_rdata[BIT_IRQEN]  = irqen_q;
            bus_rdata[BIT_BUSY]   = busy;
            bus_rdata[BIT_DONE]   = done_q;
            bus_rdata[BIT_COLL]   = coll_q;
         end
         REG_OFFS: bus_rdata[ADDR_W-1:0] = offs_q;
         REG_WDAT: bus_rdata = wdat_q;
         default:  bus_rdata = rd_word;
      endcase
   end

   AST_DONE_ON_CMPL: assert property (@(posedge clk) disable iff (!rst_n)
      cmpl |=> done_q); // R9
   AST_COLL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (coll_q && !(wr_ctrl && bus_wdata[BIT_COLL])) |=> coll_q); // R8
   AST_OFFS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !cmpl) |=> $stable(offs_q)); // R8
   AST_WDAT_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(wdat_q)); // R8
endmodule

// File: rtl/xmem_access_unit.sv
module xmem_access_unit
   import xau_pkg::*;
#(
   parameter int ADDR_W         = 8,
   parameter int DATA_W         = 16,
   parameter bit IRQ_REGISTERED = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [1:0]        bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              mem_ce,
   output logic              mem_we,
   output logic              irq
);
   if (DATA_W <= CTRL_MSB) begin : g_bad_data_w
      $error("DATA_W must hold the control word");
   end
   if (ADDR_W < 1 || ADDR_W > DATA_W) begin : g_bad_addr_w
      $error("ADDR_W must be between 1 and DATA_W");
   end

   logic              start, start_wr, busy, cmpl, irq_raw;
   logic [ADDR_W-1:0] start_addr;
   logic [DATA_W-1:0] start_wdata, rd_word;
   logic [WAIT_W-1:0] wait_cycles;

   xau_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .busy(busy), .cmpl(cmpl), .rd_word(rd_word),
      .start(start), .start_wr(start_wr), .start_addr(start_addr),
      .start_wdata(start_wdata), .wait_cycles(wait_cycles), .irq_raw(irq_raw)
   );

   xau_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
      .clk(clk), .rst_n(rst_n),
      .start(start), .start_wr(start_wr), .start_addr(start_addr),
      .start_wdata(start_wdata), .wait_cycles(wait_cycles),
      .busy(busy), .cmpl(cmpl), .rd_word(rd_word),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .mem_ce(mem_ce), .mem_we(mem_we)
   );

   if (IRQ_REGISTERED) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= irq_raw;
      end
      assign irq = irq_q;
   end else begin : g_irq_comb
      assign irq = irq_raw;
   end

   AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy); // R8
   AST_LAUNCH_RAISES_CE: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> mem_ce); // R7
endmodule

// File: tb/xmem_access_unit_tb.sv
`timescale 1ns/1ps
module xmem_access_unit_tb;
   localparam int AW = 8;
   localparam int DW = 16;
   localparam logic [1:0] A_CTRL = 2'd0, A_OFFS = 2'd1, A_WDAT = 2'd2, A_RDAT = 2'd3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_sel = 1'b0, bus_wr = 1'b0;
   logic [1:0]    bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata, mem_wdata, mem_rdata;
   logic [AW-1:0] mem_addr;
   logic          mem_ce, mem_we, irq;
   logic [DW-1:0] mem [256];

   int n_chk = 0, n_err = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   xmem_access_unit #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .mem_ce(mem_ce), .mem_we(mem_we), .irq(irq)
   );

   assign mem_rdata = mem[mem_addr];
   always @(posedge clk) if (mem_ce && mem_we) mem[mem_addr] <= mem_wdata;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [1:0] a, output logic [DW-1:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   // counts chip-enable cycles of the access in flight, checking address and write enable
   task automatic wait_idle(input string req, input bit exp_we, input logic [AW-1:0] exp_a,
                            input int exp_len);
      int n = 0;
      while (mem_ce && n < 40) begin
         chk({req, " R3 addr"}, 32'(mem_addr), 32'(exp_a));
         chk({req, " R3 we"}, 32'(mem_we), 32'(exp_we));
         n++;
         @(negedge clk);
      end
      if (exp_len >= 0) chk({req, " R3 ce length"}, n, exp_len);
   endtask

   initial begin
      #(20 * 150000);
      if (!finished) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] rd, last_rd;
      logic [AW-1:0] a;
      logic [DW-1:0] v;
      for (int i = 0; i < 256; i++) mem[i] = DW'(i * 16'h0101) ^ 16'h5A00;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 ce", 32'(mem_ce), 0);
      chk("R1 we", 32'(mem_we), 0);
      chk("R1 irq", 32'(irq), 0);
      bus_read(A_CTRL, rd); chk("R1 ctrl", 32'(rd), 0);
      bus_read(A_OFFS, rd); chk("R1 offset", 32'(rd), 0);

      // R2 R3 R6 R7 R9: write sweep in prefetch mode (offset write does not launch)
      for (int w = 0; w < 8; w++) begin
         for (int inc = 0; inc < 2; inc++) begin
            a = AW'(8'h10 + w * 4 + inc * 2);
            v = DW'(16'hC000 | (w << 8) | (inc << 7) | a);
            bus_write(A_CTRL, DW'(w | (inc << 3) | (1 << 4) | (1 << 9) | (1 << 10)));
            bus_write(A_OFFS, DW'(a));
            chk("R5 offset write no launch", 32'(mem_ce), 0);
            bus_write(A_WDAT, v);
            wait_idle("R2 write", 1'b1, a, w + 1);
            chk("R2 memory word", 32'(mem[a]), 32'(v));
            bus_read(A_OFFS, rd);
            chk("R6 offset after write", 32'(rd), 32'(AW'(a + inc)));
            bus_read(A_CTRL, rd);
            chk("R7 R9 busy/done", 32'(rd[10:8]), 32'b010);
         end
      end

      // R3 R4 R6 R10: read sweep in offset-triggered mode
      for (int w = 0; w < 8; w++) begin
         for (int inc = 0; inc < 2; inc++) begin
            a = AW'(8'h80 + w * 8 + inc * 3);
            bus_write(A_CTRL, DW'(w | (inc << 3) | (1 << 9) | (1 << 10)));
            bus_write(A_OFFS, DW'(a));
            wait_idle("R4 read", 1'b0, a, w + 1);
            bus_read(A_RDAT, rd);
            chk("R4 fetched word", 32'(rd), 32'(mem[a]));
            last_rd = mem[a];
            chk("R10 rdata read no launch", 32'(mem_ce), 0);
            bus_read(A_OFFS, rd);
            chk("R6 offset after read", 32'(rd), 32'(AW'(a + inc)));
            bus_read(A_CTRL, rd);
            chk("R9 done after read", 32'(rd[9]), 1);
         end
      end

      // R5 prefetch streaming
      bus_write(A_CTRL, DW'(1 | (1 << 3) | (1 << 4) | (1 << 9) | (1 << 10)));
      bus_write(A_OFFS, DW'(8'h40));
      chk("R5 no launch on offset", 32'(mem_ce), 0);
      bus_read(A_RDAT, rd);
      chk("R5 returns previous word", 32'(rd), 32'(last_rd));
      wait_idle("R5 fetch0", 1'b0, 8'h40, 2);
      bus_read(A_RDAT, rd);
      chk("R5 word 0x40", 32'(rd), 32'(mem[8'h40]));
      wait_idle("R5 fetch1", 1'b0, 8'h41, 2);
      bus_read(A_RDAT, rd);
      chk("R5 word 0x41", 32'(rd), 32'(mem[8'h41]));
      wait_idle("R5 fetch2", 1'b0, 8'h42, 2);
      bus_read(A_OFFS, rd);
      chk("R6 offset after stream", 32'(rd), 32'h43);

      // R7 R8 collision while busy
      bus_write(A_CTRL, DW'(7 | (1 << 4) | (1 << 9) | (1 << 10)));
      bus_write(A_OFFS, DW'(8'h30));
      bus_write(A_WDAT, 16'hAAAA);
      bus_read(A_CTRL, rd);
      chk("R7 busy during access", 32'(rd[8]), 1);
      bus_write(A_WDAT, 16'h5555);
      bus_write(A_OFFS, DW'(8'h31));
      wait_idle("R8 collide", 1'b1, 8'h30, -1);
      chk("R8 memory keeps first", 32'(mem[8'h30]), 32'hAAAA);
      bus_read(A_WDAT, rd);
      chk("R8 wdata reg unchanged", 32'(rd), 32'hAAAA);
      bus_read(A_OFFS, rd);
      chk("R8 offset unchanged", 32'(rd), 32'h30);
      bus_read(A_CTRL, rd);
      chk("R8 coll set", 32'(rd[10]), 1);
      bus_write(A_WDAT, 16'h1234);
      wait_idle("R8 clean", 1'b1, 8'h30, 8);
      bus_read(A_CTRL, rd);
      chk("R8 coll sticky", 32'(rd[10]), 1);
      bus_write(A_CTRL, DW'(7 | (1 << 4) | (1 << 10)));
      bus_read(A_CTRL, rd);
      chk("R8 coll cleared", 32'(rd[10]), 0);
      chk("R9 done untouched by coll clear", 32'(rd[9]), 1);

      // R9 completion coincides with DONE clear
      bus_write(A_CTRL, DW'((1 << 4) | (1 << 9) | (1 << 10)));
      bus_write(A_OFFS, DW'(8'h50));
      chk("R9 irq low", 32'(irq), 0);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = A_WDAT; bus_wdata = 16'hBEEF;
      @(negedge clk);
      chk("R2 zero-wait ce", 32'(mem_ce), 1);
      bus_addr = A_CTRL; bus_wdata = DW'((1 << 5) | (1 << 4) | (1 << 9));
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
      chk("R3 zero-wait ce ends", 32'(mem_ce), 0);
      chk("R9 irq after collision of set/clear", 32'(irq), 1);
      bus_read(A_CTRL, rd);
      chk("R9 done wins over clear", 32'(rd[9]), 1);
      chk("R2 word 0x50", 32'(mem[8'h50]), 32'hBEEF);
      bus_write(A_CTRL, DW'((1 << 5) | (1 << 4) | (1 << 9)));
      chk("R9 irq cleared", 32'(irq), 0);
      bus_write(A_CTRL, DW'(1 << 4));
      bus_write(A_WDAT, 16'h0F0F);
      wait_idle("R9 masked", 1'b1, 8'h50, 1);
      bus_read(A_CTRL, rd);
      chk("R9 done set masked", 32'(rd[9]), 1);
      chk("R9 irq masked", 32'(irq), 0);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule